// File: doc/BRIEF.md
# Scan Access Guard for a Cipher Core

This block sits next to a boundary-scan test controller and decides whether the scan chains of a cipher core may be used. After power-on it is in an insecure state, where both scan directions are open and the core runs on a mirror copy of the key, so the real secret never reaches a scannable flop. A one-cycle pulse on the decoded "lock" instruction moves it to a secure state. In that state both scan directions are closed, the real key is loaded and selected, and scan requests are no longer passed to the core.

The secure state is one-way. Only the asynchronous active-low power-on reset brings the block back to the insecure state. The insecure state has two sub-states, which follow the scan request of the test controller:

- `ST_INS_FUNC`: insecure functional mode.
- `ST_INS_SCAN`: insecure scan mode.

Transitions:

- `T_SCAN_ON`: `ST_INS_FUNC` to `ST_INS_SCAN`.
- `T_SCAN_OFF`: `ST_INS_SCAN` to `ST_INS_FUNC`.
- `T_LOCK`: either insecure sub-state to `ST_SEC_FUNC`.
- `T_HOLD`: `ST_SEC_FUNC` to itself, taken for any input.

The lock is stored in a separate sticky flag that is set by the lock pulse. The state machine tracks the same event, and the two are checked against each other.

Top module: `scan_guard`

## Requirements
- R1: While reset is asserted and after its release, the block is in `ST_INS_FUNC`. In this state scan_in_en=1, scan_out_en=1, key_load=0, key_sel_real=0 and core_scan=0.
- R2: In both insecure sub-states, scan_in_en=1, scan_out_en=1 and key_load=0. In `ST_SEC_FUNC`, scan_in_en=0, scan_out_en=0 and key_load=1.
- R3: key_sel_real is 1 (real key) exactly when key_load is 1. Otherwise it is 0 (mirror key).
- R4: If lock_req is 1 at a rising clock edge, the block is in `ST_SEC_FUNC` from that edge on. This holds from either insecure sub-state.
- R5: Once secure, the block stays secure for any later values of scan_req and lock_req until reset is asserted.
- R6: In the insecure states, core_scan equals the value of scan_req sampled at the previous rising edge. In `ST_SEC_FUNC`, core_scan is 0.
- R7: When lock_req and scan_req are both 1 at the same edge, the lock wins. No scan is enabled after that edge.
- R8: Asserting rst_n low returns the outputs to the R1 values immediately, with no clock edge needed, even from `ST_SEC_FUNC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scan_req | input | 1 | Scan mode request from the test controller |
| lock_req | input | 1 | Decoded lock instruction pulse |
| scan_in_en | output | 1 | Scan-in path enable |
| scan_out_en | output | 1 | Scan-out path enable |
| key_load | output | 1 | Load the real secret key into the core |
| key_sel_real | output | 1 | 1 selects the real key, 0 selects the mirror key |
| core_scan | output | 1 | Scan mode forwarded to the core |

## Verification
Scan requests are toggled on and off in the insecure state to show that core_scan tracks the request with a one-cycle delay while both enables stay open. The lock is applied once from the functional sub-state and once from the scan sub-state, and once together with a scan request, so that the three entry paths can be told apart. After the lock, dense random scan and lock patterns show that nothing reopens. Reset is then asserted between clock edges to show that the return is immediate and does not wait for a clock.

// File: rtl/scan_guard_pkg.sv
package scan_guard_pkg;
    typedef enum logic [1:0] {
        ST_INS_FUNC = 2'd0,
        ST_INS_SCAN = 2'd1,
        ST_SEC_FUNC = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic scan_in_en;
        logic scan_out_en;
        logic key_load;
        logic key_sel_real;
        logic core_scan;
    } guard_out_t;
endpackage

// File: rtl/scan_guard_flag.sv
module scan_guard_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
    end

    // R5: the lock never clears without reset
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> flag_o);
endmodule

// File: rtl/scan_guard_fsm.sv
module scan_guard_fsm
    import scan_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_req,
    input  logic         lock_req,
    output guard_state_e state_o
);
    guard_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_INS_FUNC;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INS_FUNC: begin
                if (lock_req)      state_d = ST_SEC_FUNC;
                else if (scan_req) state_d = ST_INS_SCAN;
            end
            ST_INS_SCAN: begin
                if (lock_req)      state_d = ST_SEC_FUNC;
                else if (!scan_req) state_d = ST_INS_FUNC;
            end
            ST_SEC_FUNC: state_d = ST_SEC_FUNC;
            default:     state_d = ST_INS_FUNC;
        endcase
    end

    assign state_o = state_q;

    // R4 / R7: lock request always lands in the secure state
    p_lock_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |=> state_q == ST_SEC_FUNC);
endmodule

// File: rtl/scan_guard_dec.sv
module scan_guard_dec
    import scan_guard_pkg::*;
(
    input  guard_state_e state_i,
    input  logic         locked_i,
    output guard_out_t   out_o
);
    always_comb begin
        out_o = '0;
        unique case (state_i)
            ST_INS_FUNC: begin
                out_o.scan_in_en  = 1'b1;
                out_o.scan_out_en = 1'b1;
            end
            ST_INS_SCAN: begin
                out_o.scan_in_en  = 1'b1;
                out_o.scan_out_en = 1'b1;
                out_o.core_scan   = 1'b1;
            end
            ST_SEC_FUNC: begin
                out_o.key_load     = 1'b1;
                out_o.key_sel_real = 1'b1;
            end
            default: out_o = '0;
        endcase
        // the sticky flag overrides anything the state decode produced
        if (locked_i) begin
            out_o.scan_in_en  = 1'b0;
            out_o.scan_out_en = 1'b0;
            out_o.core_scan   = 1'b0;
        end
    end
endmodule

// File: rtl/scan_guard.sv
module scan_guard
    import scan_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_req,
    input  logic lock_req,
    output logic scan_in_en,
    output logic scan_out_en,
    output logic key_load,
    output logic key_sel_real,
    output logic core_scan
);
    guard_state_e state;
    logic         locked;
    guard_out_t   outs;

    scan_guard_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lock_req),
        .flag_o (locked)
    );

    scan_guard_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_req (scan_req),
        .lock_req (lock_req),
        .state_o  (state)
    );

    scan_guard_dec u_dec (
        .state_i  (state),
        .locked_i (locked),
        .out_o    (outs)
    );

    assign scan_in_en   = outs.scan_in_en;
    assign scan_out_en  = outs.scan_out_en;
    assign key_load     = outs.key_load;
    assign key_sel_real = outs.key_sel_real;
    assign core_scan    = outs.core_scan;

    // R4: flag and state machine agree on the lock
    p_flag_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked == (state == ST_SEC_FUNC));
    // R2: scan paths and key load are never active together
    p_interlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_load && (scan_in_en || scan_out_en)));
    // R3: real key selected exactly when loaded
    p_keysel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        key_sel_real == key_load);
    // R6: no scan reaches the core once locked
    p_noscan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !core_scan);
endmodule

// File: tb/tb_scan_guard.sv
module tb_scan_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_req = 1'b0;
    logic lock_req = 1'b0;
    logic scan_in_en, scan_out_en, key_load, key_sel_real, core_scan;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // behavioural reference
    bit m_sec = 0;
    bit m_scan = 0;

    always #2 clk = ~clk;

    scan_guard dut (
        .clk(clk), .rst_n(rst_n), .scan_req(scan_req), .lock_req(lock_req),
        .scan_in_en(scan_in_en), .scan_out_en(scan_out_en), .key_load(key_load),
        .key_sel_real(key_sel_real), .core_scan(core_scan)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sec = 0; m_scan = 0;
        end else begin
            if (lock_req) m_sec = 1;
            m_scan = m_sec ? 0 : scan_req;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual cycles=%0d expected <=5000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, "/R2 scan_in_en"},  scan_in_en,   !m_sec);
        chk({tag, "/R2 scan_out_en"}, scan_out_en,  !m_sec);
        chk({tag, "/R2 key_load"},    key_load,     m_sec);
        chk({tag, "/R3 key_sel_real"}, key_sel_real, m_sec);
        chk({tag, "/R6 core_scan"},   core_scan,    m_scan);
    endtask

    task automatic step(input string tag, input logic req, input logic lk);
        @(negedge clk);
        compare_all(tag);
        scan_req = req;
        lock_req = lk;
    endtask

    initial begin
        #1;
        compare_all("R1 in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 after reset", 0, 0);
        // R6: scan request tracking while insecure
        step("R6", 1, 0);
        step("R6", 1, 0);
        step("R6", 0, 0);
        step("R6", 1, 0);
        step("R6", 0, 0);
        // R4: lock from functional sub-state
        step("R4 func", 0, 1);
        step("R4", 0, 0);
        // R5: random patterns after lock
        for (int i = 0; i < 200; i++)
            step("R5", 1'($urandom_range(1)), 1'($urandom_range(1)));
        step("R5", 0, 0);
        // R8: async reset mid-cycle
        @(posedge clk); #1;
        rst_n = 1'b0; #1;
        compare_all("R8 async");
        @(negedge clk); rst_n = 1'b1;
        // R4: lock from scan sub-state
        step("R4 pre", 1, 0);
        step("R4 scan", 1, 0);
        step("R4 scan", 1, 1);
        step("R4 scan", 1, 0);
        step("R5", 1, 0);
        // R7: lock and scan together from functional state
        @(negedge clk); rst_n = 1'b0; #1; compare_all("R8");
        @(negedge clk); rst_n = 1'b1;
        step("R7", 1, 1);
        step("R7", 1, 0);
        step("R7", 1, 0);
        for (int i = 0; i < 50; i++)
            step("R6 rand", 1'($urandom_range(1)), 1'b0);
        step("end", 0, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule